// File: doc/BRIEF.md
# Packet Switch Port with Selectable Flow Control

This block is one input port feeding one output channel of a packet switch. Packets are made of flits. Each flit carries a two-bit kind marker, and the head flit also carries a destination and a length. Incoming flits are written into a local buffer. A launch controller looks up the output port for the packet and then sends the flits over a valid/ready output link. The downstream side can hold `out_ready` low at any time to stall the link.

A static parameter picks one of three flow-control schemes:
- **Store-and-forward** holds the whole packet in the buffer before its first flit leaves.
- **Virtual cut-through** starts sending right after the route is known. It admits a packet only when the buffer has room for all of it, so a blocked packet is always absorbed in full.
- **Wormhole** also starts right after routing, but it needs only a small buffer. It stops accepting flits whenever that buffer is full, so a blocked packet stays spread across the upstream stages.

The input controller has three states:
- HEAD: waiting for a head flit. HEAD goes to BODY when a head without a tail marker is kept. HEAD goes to DROP when an oversized head is discarded.
- BODY: accepting the rest of a kept packet. BODY returns to HEAD on the tail flit.
- DROP: discarding the rest of an oversized packet. DROP returns to HEAD on the tail flit.

The launch controller has four states:
- IDLE: no packet in progress. IDLE goes to ROUTE when the buffer is not empty.
- ROUTE: counts the routing cycles. After `ROUTE_LAT` cycles it goes to SEND. In store-and-forward mode it goes to HOLD instead if no tail is buffered yet.
- HOLD: waits for the packet's tail. HOLD goes to SEND once a tail is buffered.
- SEND: offers buffered flits on the output link. SEND goes back to IDLE when the tail flit is accepted downstream.

Top module: `fc_switch_port`

## Requirements
- R1: After reset, `out_valid` and `err_oversize` are 0. With `in_valid` low, `in_ready` is 1.
- R2: Kind encoding is 00 body, 01 head, 10 tail, 11 single-flit packet. Bit 0 marks a head and bit 1 marks a tail. In a head flit, bits [3:0] of the data are the destination and bits [7:4] are the packet length in flits. Flits leave in arrival order with kind and data unchanged. Every flit of a kept packet leaves exactly once.
- R3: `out_port` equals the head's destination modulo `NUM_PORTS`. It holds that value for every flit of the packet.
- R4: In cut-through and wormhole modes, a head written at clock edge e into an idle, empty port is offered right after edge e+1+`ROUTE_LAT`. This does not wait for the tail.
- R5: In store-and-forward mode, no flit of a packet is offered until its tail is stored. The head is offered after edge max(e+1+`ROUTE_LAT`, t+1), where t is the edge that stored the tail.
- R6: In store-and-forward and cut-through modes, a head is accepted only when the free buffer space is at least its length. Once a head is accepted, every further flit of that packet is accepted even while the output is stalled.
- R7: In wormhole mode, `in_ready` is high exactly when the buffer is not full, whatever the packet length. A blocked head therefore stops the input once `DEPTH` flits are held.
- R8: In store-and-forward and cut-through modes, a head whose length exceeds `DEPTH` is accepted and discarded along with the rest of its packet. `err_oversize` pulses for one cycle after the head's edge, and none of the packet's flits is offered. Wormhole mode never raises `err_oversize`.
- R9: Once a packet's head has been sent, no other packet's head is offered until that packet's tail has been sent.
- R10: While `out_valid` is high and `out_ready` is low, the offered flit stays unchanged. At most one flit moves per cycle, and one flit leaves on every cycle with both signals high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input flit present |
| in_ready | output | 1 | Port takes the input flit this cycle |
| in_kind | input | 2 | Input flit kind marker |
| in_data | input | FLIT_W | Input flit payload; destination and length in a head |
| out_valid | output | 1 | Output flit offered |
| out_ready | input | 1 | Downstream takes the offered flit |
| out_kind | output | 2 | Offered flit kind marker |
| out_data | output | FLIT_W | Offered flit payload |
| out_port | output | PORT_W | Routed output port for the current packet |
| err_oversize | output | 1 | One-cycle pulse: a packet too long for the buffer was discarded |

## Verification
- `in_ready` is combinational and is due in the same cycle as the flit it answers.
- `err_oversize` is due one cycle after the edge that takes an oversized head.
- The first flit of a packet is due 1+`ROUTE_LAT` edges after its head is stored. In store-and-forward mode it is due at the later of that edge and one edge past the tail's storage.
- Each later flit is due one cycle after the previous one is taken, as long as it is buffered.

A behavioural queue model in the bench is advanced on every rising edge. It is compared with the outputs one time unit after each falling edge, so every due cycle is checked. Both an unstalled and a stalled first-packet latency are covered for each mode.

// File: rtl/fc_pkg.sv
`timescale 1ns/1ps
package fc_pkg;
    typedef enum logic [1:0] {
        FC_STORE_FWD   = 2'd0,
        FC_CUT_THROUGH = 2'd1,
        FC_WORMHOLE    = 2'd2
    } fc_mode_e;

    localparam logic [1:0] KIND_BODY   = 2'b00;
    localparam logic [1:0] KIND_HEAD   = 2'b01;
    localparam logic [1:0] KIND_TAIL   = 2'b10;
    localparam logic [1:0] KIND_SINGLE = 2'b11;
endpackage

// File: rtl/fc_flit_fifo.sv
`timescale 1ns/1ps
module fc_flit_fifo #(
    parameter int W     = 18,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [W-1:0]     wr_data,
    input  logic             rd_en,
    output logic [W-1:0]     rd_data,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic             empty,
    output logic             full
);
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wptr, rptr;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (wr_en) mem[wptr] <= wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (wr_en) wptr <= bump(wptr);
            if (rd_en) rptr <= bump(rptr);
            unique case ({wr_en, rd_en})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    assign rd_data = mem[rptr];
    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));

    // R7
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !full);
    // R2
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> !empty);
endmodule

// File: rtl/fc_admit.sv
`timescale 1ns/1ps
module fc_admit import fc_pkg::*; #(
    parameter fc_mode_e MODE  = FC_CUT_THROUGH,
    parameter int       DEPTH = 8,
    parameter int       LEN_W = 4,
    parameter int       CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       in_kind,
    input  logic [LEN_W-1:0] hdr_len,
    input  logic [CNT_W-1:0] fifo_count,
    input  logic             fifo_full,
    output logic             in_ready,
    output logic             wr_en,
    output logic             err_oversize
);
    typedef enum logic [1:0] {ADM_HEAD, ADM_BODY, ADM_DROP} adm_st_e;

    localparam int  CMP_W   = ((LEN_W > CNT_W) ? LEN_W : CNT_W) + 1;
    localparam bit  RESERVE = (MODE != FC_WORMHOLE);

    adm_st_e          st, st_n;
    logic             drop_hd;
    logic [CMP_W-1:0] depth_w, free_w, len_w;
    logic             too_long, fits;

    assign depth_w  = CMP_W'(DEPTH);
    assign free_w   = depth_w - CMP_W'(fifo_count);
    assign len_w    = CMP_W'(hdr_len);
    assign too_long = len_w > depth_w;
    assign fits     = len_w <= free_w;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st           <= ADM_HEAD;
            err_oversize <= 1'b0;
        end else begin
            st           <= st_n;
            err_oversize <= drop_hd;
        end
    end

    // outputs and next state
    always_comb begin
        st_n     = st;
        in_ready = 1'b0;
        wr_en    = 1'b0;
        drop_hd  = 1'b0;
        unique case (st)
            ADM_HEAD: begin
                if (!RESERVE) begin
                    in_ready = !fifo_full;
                end else if (too_long) begin
                    in_ready = 1'b1;
                    drop_hd  = in_valid;
                end else begin
                    in_ready = fits;
                end
                if (in_valid && in_ready) begin
                    wr_en = !drop_hd;
                    if (!in_kind[1]) st_n = drop_hd ? ADM_DROP : ADM_BODY;
                end
            end
            ADM_BODY: begin
                in_ready = !fifo_full;
                wr_en    = in_valid && in_ready;
                if (wr_en && in_kind[1]) st_n = ADM_HEAD;
            end
            ADM_DROP: begin
                in_ready = 1'b1;
                if (in_valid && in_kind[1]) st_n = ADM_HEAD;
            end
            default: st_n = ADM_HEAD;
        endcase
    end

    // R8
    err_after_head_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_oversize |-> $past(in_valid && in_ready && in_kind[0]));
    // R6
    reserved_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (RESERVE && st == ADM_BODY) |-> !fifo_full);
endmodule

// File: rtl/fc_launch.sv
`timescale 1ns/1ps
module fc_launch import fc_pkg::*; #(
    parameter fc_mode_e MODE      = FC_CUT_THROUGH,
    parameter int       ROUTE_LAT = 2,
    parameter int       DEST_W    = 4,
    parameter int       NUM_PORTS = 4,
    parameter int       CNT_W     = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          fifo_empty,
    input  logic [1:0]                    front_kind,
    input  logic [DEST_W-1:0]             front_dest,
    input  logic                          wr_tail,
    input  logic                          out_ready,
    output logic                          out_valid,
    output logic                          pop,
    output logic [$clog2(NUM_PORTS)-1:0]  out_port
);
    typedef enum logic [1:0] {L_IDLE, L_ROUTE, L_HOLD, L_SEND} launch_st_e;

    localparam int PORT_W    = $clog2(NUM_PORTS);
    localparam int RC_W      = (ROUTE_LAT > 1) ? $clog2(ROUTE_LAT) : 1;
    localparam bit NEED_TAIL = (MODE == FC_STORE_FWD);

    launch_st_e        st, st_n;
    logic [RC_W-1:0]   rcnt;
    logic [CNT_W-1:0]  tails_q;
    logic              pop_tail;
    logic              mid_q;
    logic [PORT_W-1:0] route_w;

    assign route_w  = PORT_W'(32'(front_dest) % NUM_PORTS);
    assign pop_tail = pop && front_kind[1];

    // state register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st       <= L_IDLE;
            rcnt     <= '0;
            out_port <= '0;
            tails_q  <= '0;
            mid_q    <= 1'b0;
        end else begin
            st   <= st_n;
            rcnt <= (st == L_ROUTE) ? rcnt + 1'b1 : '0;
            if (st == L_IDLE && !fifo_empty) out_port <= route_w;
            unique case ({wr_tail, pop_tail})
                2'b10:   tails_q <= tails_q + 1'b1;
                2'b01:   tails_q <= tails_q - 1'b1;
                default: tails_q <= tails_q;
            endcase
            if (pop) mid_q <= !front_kind[1];
        end
    end

    // outputs and next state
    always_comb begin
        st_n      = st;
        out_valid = 1'b0;
        pop       = 1'b0;
        unique case (st)
            L_IDLE:  if (!fifo_empty) st_n = L_ROUTE;
            L_ROUTE: if (rcnt == RC_W'(ROUTE_LAT-1))
                         st_n = (NEED_TAIL && tails_q == '0) ? L_HOLD : L_SEND;
            L_HOLD:  if (tails_q != '0) st_n = L_SEND;
            L_SEND: begin
                out_valid = !fifo_empty;
                pop       = out_valid && out_ready;
                if (pop && front_kind[1]) st_n = L_IDLE;
            end
            default: st_n = L_IDLE;
        endcase
    end

    // R5
    sf_tail_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (NEED_TAIL && out_valid) |-> (tails_q != '0));
    // R9
    no_interleave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mid_q) |-> !front_kind[0]);
    // R3
    port_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && mid_q) |-> $stable(out_port));
endmodule

// File: rtl/fc_switch_port.sv
`timescale 1ns/1ps
module fc_switch_port import fc_pkg::*; #(
    parameter fc_mode_e MODE      = FC_CUT_THROUGH,
    parameter int       FLIT_W    = 16,
    parameter int       DEST_W    = 4,
    parameter int       MAX_PKT   = 15,
    parameter int       DEPTH     = 8,
    parameter int       NUM_PORTS = 4,
    parameter int       ROUTE_LAT = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    output logic                         in_ready,
    input  logic [1:0]                   in_kind,
    input  logic [FLIT_W-1:0]            in_data,
    output logic                         out_valid,
    input  logic                         out_ready,
    output logic [1:0]                   out_kind,
    output logic [FLIT_W-1:0]            out_data,
    output logic [$clog2(NUM_PORTS)-1:0] out_port,
    output logic                         err_oversize
);
    localparam int LEN_W = $clog2(MAX_PKT+1);
    localparam int CNT_W = $clog2(DEPTH+1);
    localparam int ENT_W = 2 + FLIT_W;

    logic             wr_en, pop, fifo_empty, fifo_full;
    logic [CNT_W-1:0] fifo_count;
    logic [ENT_W-1:0] front;

    fc_admit #(
        .MODE(MODE), .DEPTH(DEPTH), .LEN_W(LEN_W), .CNT_W(CNT_W)
    ) u_admit (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_kind(in_kind),
        .hdr_len(in_data[DEST_W +: LEN_W]),
        .fifo_count(fifo_count), .fifo_full(fifo_full),
        .in_ready(in_ready), .wr_en(wr_en), .err_oversize(err_oversize)
    );

    fc_flit_fifo #(.W(ENT_W), .DEPTH(DEPTH)) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_data({in_kind, in_data}),
        .rd_en(pop), .rd_data(front),
        .count(fifo_count), .empty(fifo_empty), .full(fifo_full)
    );

    fc_launch #(
        .MODE(MODE), .ROUTE_LAT(ROUTE_LAT), .DEST_W(DEST_W),
        .NUM_PORTS(NUM_PORTS), .CNT_W(CNT_W)
    ) u_launch (
        .clk(clk), .rst_n(rst_n),
        .fifo_empty(fifo_empty),
        .front_kind(front[ENT_W-1 -: 2]),
        .front_dest(front[DEST_W-1:0]),
        .wr_tail(wr_en && in_kind[1]),
        .out_ready(out_ready),
        .out_valid(out_valid), .pop(pop), .out_port(out_port)
    );

    assign out_kind = front[ENT_W-1 -: 2];
    assign out_data = front[FLIT_W-1:0];

    // R10
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_kind)));
endmodule

// File: tb/fc_switch_port_tb.sv
`timescale 1ns/1ps
module fc_mode_lane import fc_pkg::*; #(
    parameter fc_mode_e MODE  = FC_CUT_THROUGH,
    parameter int       DEPTH = 8,
    parameter int       RL    = 2,
    parameter int       HALF  = 5
) (
    input logic clk,
    input logic rst_n
);
    int  n_vec = 0;
    int  n_bad = 0;
    bit  done  = 0;

    logic        in_valid = 1'b0;
    logic [1:0]  in_kind  = 2'b00;
    logic [15:0] in_data  = '0;
    logic        out_ready = 1'b1;
    logic        in_ready, out_valid, err;
    logic [1:0]  out_kind;
    logic [15:0] out_data;
    logic [1:0]  out_port;

    fc_switch_port #(.MODE(MODE), .DEPTH(DEPTH), .ROUTE_LAT(RL)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_kind(in_kind), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_kind(out_kind),
        .out_data(out_data), .out_port(out_port), .err_oversize(err)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s mode%0d: actual %0h expected %0h", tag, int'(MODE), act, exp);
        end
    endtask

    // behavioural reference
    logic [17:0] q[$];
    int  in_ph = 0, out_ph = 0, timer = 0, tails = 0, route_m = 0;
    bit  err_m = 0;
    int  cyc = 0, first_hd = -1, first_out = -1;
    int  ready_mode = 0, pkt_id = 0, exp_out = 0, n_out = 0, n_err = 0;
    bit  started = 0, mid = 0, prev_stall = 0;
    logic [17:0] prev_flit = '0;

    function automatic bit m_rdy();
        int len = int'(in_data[7:4]);
        if (MODE == FC_WORMHOLE) return q.size() < DEPTH;
        if (in_ph == 0) return (len > DEPTH) || ((DEPTH - q.size()) >= len);
        if (in_ph == 1) return q.size() < DEPTH;
        return 1'b1;
    endfunction

    always @(posedge clk) begin
        bit acc, pop, ptail, wtail, drop;
        logic [17:0] fr;
        cyc++;
        if (!rst_n) begin
            q.delete(); in_ph = 0; out_ph = 0; timer = 0; tails = 0; route_m = 0; err_m = 0;
        end else begin
            acc   = in_valid && m_rdy();
            pop   = (out_ph == 3) && (q.size() > 0) && out_ready;
            fr    = (q.size() > 0) ? q[0] : '0;
            ptail = pop && fr[17];
            wtail = 0; drop = 0;
            case (out_ph)
                0: if (q.size() > 0) begin out_ph = 1; timer = 0; route_m = int'(fr[3:0]) % 4; end
                1: if (timer == RL-1) out_ph = (MODE == FC_STORE_FWD && tails == 0) ? 2 : 3;
                   else timer++;
                2: if (tails > 0) out_ph = 3;
                default: if (ptail) out_ph = 0;
            endcase
            if (pop) void'(q.pop_front());
            if (acc) begin
                if (in_ph == 2) begin
                    if (in_kind[1]) in_ph = 0;
                end else if (MODE != FC_WORMHOLE && in_ph == 0 && int'(in_data[7:4]) > DEPTH) begin
                    drop = 1;
                    if (!in_kind[1]) in_ph = 2;
                end else begin
                    q.push_back({in_kind, in_data});
                    wtail = in_kind[1];
                    in_ph = in_kind[1] ? 0 : 1;
                    if (in_kind[0] && first_hd < 0) first_hd = cyc;
                end
            end
            tails = tails + int'(wtail) - int'(ptail);
            err_m = drop;
        end
    end

    always @(negedge clk) begin
        bit m_valid;
        case (ready_mode)
            0:       out_ready = 1'b1;
            1:       out_ready = (cyc % 3) != 2;
            default: out_ready = 1'b0;
        endcase
        #1;
        if (rst_n && started) begin
            m_valid = (out_ph == 3) && (q.size() > 0);
            chk(out_valid === m_valid, (MODE == FC_STORE_FWD) ? "R5" : "R4", out_valid, m_valid);
            if (out_valid && m_valid) begin
                chk({out_kind, out_data} === q[0], "R2", {out_kind, out_data}, q[0]);
                chk(int'(out_port) == route_m, "R3", out_port, route_m);
            end
            if (in_valid)
                chk(in_ready === m_rdy(), (MODE == FC_WORMHOLE) ? "R7" : "R6", in_ready, m_rdy());
            chk(err === err_m, "R8", err, err_m);
            if (prev_stall)
                chk(out_valid && ({out_kind, out_data} == prev_flit), "R10", {out_kind, out_data}, prev_flit);
            chk(!(out_valid && mid && out_kind[0]), "R9", out_kind, 0);
            if (out_valid && first_out < 0) begin
                first_out = cyc;
                chk((first_out - first_hd) == ((MODE == FC_STORE_FWD) ? ((1+RL > 4) ? 1+RL : 4) : 1+RL),
                    (MODE == FC_STORE_FWD) ? "R5" : "R4", first_out - first_hd,
                    (MODE == FC_STORE_FWD) ? ((1+RL > 4) ? 1+RL : 4) : 1+RL);
            end
            if (out_valid && out_ready) begin
                n_out++;
                mid = !out_kind[1];
            end
            if (err) n_err++;
            prev_stall = out_valid && !out_ready;
            prev_flit  = {out_kind, out_data};
        end
    end

    task automatic send_pkt(input int dest, input int len, input int gap);
        bit ok;
        for (int i = 0; i < len; i++) begin
            in_valid = 1'b1;
            in_kind  = (len == 1) ? KIND_SINGLE : (i == 0) ? KIND_HEAD :
                       (i == len-1) ? KIND_TAIL : KIND_BODY;
            in_data  = (i == 0) ? {8'h00, 4'(len), 4'(dest)} : {8'(pkt_id), 8'(i)};
            do begin
                #(HALF-1);
                ok = in_ready;
                @(negedge clk);
            end while (!ok);
            in_valid = 1'b0;
            repeat (gap) @(negedge clk);
        end
        if (!(MODE != FC_WORMHOLE && len > DEPTH)) exp_out += len;
        pkt_id++;
    endtask

    initial begin
        wait (rst_n);
        @(negedge clk);
        #1;
        // R1: reset state seen at the ports
        chk(out_valid === 1'b0, "R1", out_valid, 0);
        chk(err === 1'b0, "R1", err, 0);
        chk(in_ready === 1'b1, "R1", in_ready, 1);
        started = 1;
        @(negedge clk);
        send_pkt(5, 4, 0);                       // latency, no stall
        repeat (12) @(negedge clk);
        fork
            send_pkt(6, 4, 0);                   // head blocked downstream
            begin ready_mode = 2; repeat (12) @(negedge clk); ready_mode = 0; end
        join
        ready_mode = 1;                          // periodic stall
        send_pkt(3, 3, 0);
        send_pkt(6, 5, 0);
        send_pkt(1, 1, 0);
        send_pkt(9, 4, 2);
        repeat (30) @(negedge clk);
        ready_mode = 0;
        send_pkt(2, 10, 0);                      // longer than an 8-deep buffer
        send_pkt(7, 2, 0);
        repeat (20) @(negedge clk);
        fork
            begin send_pkt(4, 6, 0); send_pkt(11, 5, 0); end
            begin ready_mode = 2; repeat (20) @(negedge clk); ready_mode = 0; end
        join
        repeat (60) @(negedge clk);
        chk(n_out == exp_out, "R2", n_out, exp_out);
        chk(n_err == ((MODE == FC_WORMHOLE) ? 0 : 1), "R8", n_err, (MODE == FC_WORMHOLE) ? 0 : 1);
        done = 1;
    end
endmodule

module fc_switch_port_tb;
    import fc_pkg::*;
    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    bit   timeout = 0;

    always #(CLK_P/2) clk = ~clk;

    fc_mode_lane #(.MODE(FC_STORE_FWD),   .DEPTH(8), .HALF(CLK_P/2)) u_lane_sf (.clk(clk), .rst_n(rst_n));
    fc_mode_lane #(.MODE(FC_CUT_THROUGH), .DEPTH(8), .HALF(CLK_P/2)) u_lane_ct (.clk(clk), .rst_n(rst_n));
    fc_mode_lane #(.MODE(FC_WORMHOLE),    .DEPTH(2), .HALF(CLK_P/2)) u_lane_wh (.clk(clk), .rst_n(rst_n));

    initial begin
        int vec, bad;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fork
            wait (u_lane_sf.done && u_lane_ct.done && u_lane_wh.done);
            begin repeat (20000) @(posedge clk); timeout = 1; end
        join_any
        vec = u_lane_sf.n_vec + u_lane_ct.n_vec + u_lane_wh.n_vec;
        bad = u_lane_sf.n_bad + u_lane_ct.n_bad + u_lane_wh.n_bad;
        if (timeout) begin
            vec++;
            bad++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule